// File: doc/BRIEF.md
# IR Symbol FIFO Sequencer

This block plays out a queue of timed infrared symbols. The host writes symbol words into a 128-entry FIFO. The sequencer pops the words in order and holds each one for a programmed interval. A mark symbol drives the carrier-gate output high for its interval. A space symbol keeps the output low. Each symbol's interval is a 10-bit minus-one count of one of four timebase strobes that arrive from outside: 1 µs, 10 µs, 100 µs or one carrier period. The carrier waveform itself is produced elsewhere and is only gated by this block.

Refill is paced by a level-threshold interrupt. When the FIFO level falls to the programmed threshold or below, a pending flag rises and drives the interrupt line. The host then pushes at most the free space and clears the flag by writing the control word with the pending bit at 0. The write port has no back-pressure: `wr_valid` is taken in every cycle it is high. The host is responsible for never pushing past the free space. A symbol push that meets a full FIFO is discarded and recorded in a sticky overflow flag.

Top module: `irsym_sequencer`

## Requirements
- R1: A write with `wr_sel`=0 pushes a symbol only when bit 16 of `wr_data` is 1. A write with bit 16 at 0, or any write with `wr_sel`=1, leaves `fifo_level` and `busy` unchanged.
- R2: The FIFO holds up to 128 symbols, and `fifo_level` reports the stored count. After reset, `fifo_level`, `busy`, `carrier_gate`, `irq` and `overflow` are all 0.
- R3: Symbol bit 12 at 1 makes `carrier_gate` 1 for the whole interval. Bit 12 at 0 makes `carrier_gate` 0 for the whole interval.
- R4: Symbol bits 11:10 pick the strobe that times the interval: 0 selects `tick_1us`, 1 selects `tick_10us`, 2 selects `tick_100us` and 3 selects `tick_carrier`. Strobes of the other kinds do not advance it.
- R5: Symbol bits 9:0 hold D, and the interval ends on the (D+1)th selected strobe taken after the symbol loads. D=1023 gives 1024 units.
- R6: Symbols play in write order. The next symbol loads on the same edge that ends the current one, so there is no gap, and `busy` stays 1 throughout.
- R7: When the last symbol ends and the FIFO is empty, `busy` and `carrier_gate` fall to 0. Playback restarts on the next pushed symbol.
- R8: A write with `wr_sel`=1 sets the threshold from bits 7:0 (32 after reset) and the interrupt enable from bit 8 (0 after reset).
- R9: `irq` is the pending flag. It is set in the cycle after the condition (enable is 1 and `fifo_level` ≤ threshold) changes from false to true, and it never sets while the enable is 0.
- R10: A control write with bit 16 at 0 clears the pending flag. A control write with bit 16 at 1 leaves it as it was. A new set takes priority over a clear in the same cycle.
- R11: A symbol push while the FIFO is full is discarded, leaves `fifo_level` at 128, and sets `overflow`. `overflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, always accepted |
| wr_sel | input | 1 | 0 = symbol word, 1 = control word |
| wr_data | input | 17 | Write data |
| tick_1us | input | 1 | 1 µs timebase strobe |
| tick_10us | input | 1 | 10 µs timebase strobe |
| tick_100us | input | 1 | 100 µs timebase strobe |
| tick_carrier | input | 1 | Carrier-period strobe |
| carrier_gate | output | 1 | High during mark intervals |
| irq | output | 1 | Threshold interrupt (pending flag) |
| busy | output | 1 | A symbol is being played |
| fifo_level | output | 8 | Number of stored symbols |
| overflow | output | 1 | Sticky full-FIFO drop flag |

## Verification
A wrong countdown or a wrong strobe selection shows up on `carrier_gate` as a segment whose length in strobes of the expected kind is not D+1. The scoreboard reports it at the edge that closes that segment. A read pointer or level that has drifted shows up at the next symbol boundary, either as a gate level out of the written order or as `busy` falling early. A fault in the threshold logic shows up on `irq` within two cycles of the level crossing, or of the control write that should have cleared it.

// File: rtl/irsym_pkg.sv
package irsym_pkg;
  localparam int DLY_W   = 10;
  localparam int TB_W    = 2;
  localparam int N_TB    = 4;
  localparam int WORD_W  = 17;
  // field positions shared by the writer and the decoder
  localparam int PUSH_BIT = 16;
  localparam int MARK_BIT = 12;
  localparam int TB_LSB   = 10;
  localparam int PEND_BIT = 16;
  localparam int EN_BIT   = 8;
  localparam int THR_W    = 8;

  typedef enum logic [TB_W-1:0] {
    TB_1US  = 2'd0,
    TB_10US = 2'd1,
    TB_100US = 2'd2,
    TB_CAR  = 2'd3
  } tbase_e;

  typedef struct packed {
    logic             mark;
    tbase_e           tb;
    logic [DLY_W-1:0] delay;
  } sym_t;

  localparam int SYM_W = $bits(sym_t);
endpackage

// File: rtl/irsym_fifo.sv
module irsym_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level)));
endmodule

// File: rtl/irsym_player.sv
module irsym_player
  import irsym_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_TB-1:0] ticks,
  input  sym_t            head,
  input  logic            empty,
  output logic            pop,
  output logic            gate,
  output logic            busy
);
  logic             busy_q, mark_q;
  tbase_e           tb_q;
  logic [DLY_W-1:0] cnt_q;
  logic             tick_sel, done;

  assign tick_sel = ticks[tb_q];
  assign done     = busy_q && tick_sel && (cnt_q == '0);
  assign pop      = !empty && (!busy_q || done);
  assign gate     = busy_q && mark_q;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mark_q <= 1'b0;
      tb_q   <= TB_1US;
      cnt_q  <= '0;
    end else if (pop) begin
      busy_q <= 1'b1;
      mark_q <= head.mark;
      tb_q   <= head.tb;
      cnt_q  <= head.delay;
    end else if (done) begin
      busy_q <= 1'b0;
      mark_q <= 1'b0;
    end else if (busy_q && tick_sel) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  cnt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(pop) && (cnt_q != $past(cnt_q))) |-> $past(tick_sel));
endmodule

// File: rtl/irsym_irq.sv
module irsym_irq
  import irsym_pkg::*;
#(
  parameter int LW         = 8,
  parameter int THRESH_DEF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] ctrl_data,
  input  logic [LW-1:0]     level,
  output logic              pending
);
  logic [THR_W-1:0] thresh_q;
  logic             en_q, cond, cond_q, set;

  assign cond = en_q && (int'(level) <= int'(thresh_q));
  assign set  = cond && !cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thresh_q <= THR_W'(THRESH_DEF);
      en_q     <= 1'b0;
      cond_q   <= 1'b0;
      pending  <= 1'b0;
    end else begin
      cond_q <= cond;
      if (ctrl_we) begin
        thresh_q <= ctrl_data[THR_W-1:0];
        en_q     <= ctrl_data[EN_BIT];
      end
      if (set) pending <= 1'b1;
      else if (ctrl_we && !ctrl_data[PEND_BIT]) pending <= 1'b0;
    end
  end

  // R9
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(en_q));
  // R10
  pend_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> ($past(ctrl_we) && !$past(ctrl_data[PEND_BIT])));
endmodule

// File: rtl/irsym_sequencer.sv
module irsym_sequencer
  import irsym_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int THRESH_DEF = 32,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tick_1us,
  input  logic              tick_10us,
  input  logic              tick_100us,
  input  logic              tick_carrier,
  output logic              carrier_gate,
  output logic              irq,
  output logic              busy,
  output logic [LW-1:0]     fifo_level,
  output logic              overflow
);
  logic             sym_we, ctrl_we, full, empty, pop;
  logic [SYM_W-1:0] fifo_dout;
  sym_t             head;
  logic             unused_bits;

  assign unused_bits = &{1'b0, wr_data[15:13]};
  assign sym_we  = wr_valid && !wr_sel && wr_data[PUSH_BIT];
  assign ctrl_we = wr_valid && wr_sel;
  assign head    = sym_t'(fifo_dout);

  irsym_fifo #(.W(SYM_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (sym_we),
    .din   ({wr_data[MARK_BIT], wr_data[TB_LSB +: TB_W], wr_data[DLY_W-1:0]}),
    .pop   (pop),
    .dout  (fifo_dout),
    .level (fifo_level),
    .full  (full),
    .empty (empty)
  );

  irsym_player u_player (
    .clk   (clk),
    .rst_n (rst_n),
    .ticks ({tick_carrier, tick_100us, tick_10us, tick_1us}),
    .head  (head),
    .empty (empty),
    .pop   (pop),
    .gate  (carrier_gate),
    .busy  (busy)
  );

  irsym_irq #(.LW(LW), .THRESH_DEF(THRESH_DEF)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_data (wr_data),
    .level     (fifo_level),
    .pending   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else if (sym_we && full) overflow <= 1'b1;
  end

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);
  // R7
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(fifo_level) == '0));
  // R3
  gate_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_gate != $past(carrier_gate)) |-> ($past(pop) || !busy));
endmodule

// File: tb/irsym_sequencer_test.sv
module irsym_sequencer_test;
  typedef struct {
    int mark;
    int tb;
    int delay;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0, wr_sel = 0;
  logic [16:0] wr_data = '0;
  logic        t1 = 0, t10 = 0, t100 = 0, tcar = 0;
  logic        carrier_gate, irq, busy, overflow;
  logic [7:0]  fifo_level;

  int checks = 0, fails = 0;
  exp_t q[$];
  bit mon_en = 1;
  int c1 = 0, c10 = 0, c100 = 0, ccar = 0;

  always #10 clk = ~clk;

  irsym_sequencer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_1us(t1), .tick_10us(t10), .tick_100us(t100), .tick_carrier(tcar),
    .carrier_gate(carrier_gate), .irq(irq), .busy(busy),
    .fifo_level(fifo_level), .overflow(overflow)
  );

  // strobes with distinct periods: 3, 5, 7, 4 cycles
  always @(negedge clk) begin
    c1   <= (c1 == 2) ? 0 : c1 + 1;     t1   <= (c1 == 2);
    c10  <= (c10 == 4) ? 0 : c10 + 1;   t10  <= (c10 == 4);
    c100 <= (c100 == 6) ? 0 : c100 + 1; t100 <= (c100 == 6);
    ccar <= (ccar == 3) ? 0 : ccar + 1; tcar <= (ccar == 3);
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [16:0] d);
    wr_valid = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_data = '0;
  endtask

  task automatic push_sym(int mark, int tb, int delay, bit track);
    exp_t e;
    e.mark = mark; e.tb = tb; e.delay = delay;
    if (track) q.push_back(e);
    wr(0, 17'(32'h10000 | (mark << 12) | (tb << 10) | delay));
  endtask

  task automatic drain();
    while (q.size() > 0 || busy) @(negedge clk);
  endtask

  // monitor: counts selected strobes per gate segment and checks it against the queue
  logic pb = 0, pg = 0;
  int   tcnt = 0;
  always @(negedge clk) begin
    logic [3:0] tv;
    tv = {tcar, t100, t10, t1};
    if (!rst_n) begin
      pb = 0; pg = 0; tcnt = 0;
    end else begin
      if (pb && q.size() > 0 && tv[q[0].tb]) tcnt++;
      if (pb && (!busy || carrier_gate != pg)) begin
        if (mon_en) begin
          if (q.size() == 0) chk("R6", 1, 0, "segment with no queued symbol");
          else begin
            chk("R3", int'(pg), q[0].mark, "gate level of segment");
            chk("R5", tcnt, q[0].delay + 1, "strobes in segment (R4 selection)");
            void'(q.pop_front());
          end
        end
        tcnt = 0;
      end
      if (busy && !pb) tcnt = 0;
      pb = busy; pg = carrier_gate;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2", int'(fifo_level), 0, "level after reset");
    chk("R2", int'(busy), 0, "busy after reset");
    chk("R2", int'(carrier_gate), 0, "gate after reset");
    chk("R2", int'(irq), 0, "irq after reset");
    chk("R2", int'(overflow), 0, "overflow after reset");

    // R1: no push without bit 16, nor from a control write
    wr(0, 17'h01003);
    wr(1, 17'h00020);
    repeat (2) @(negedge clk);
    chk("R1", int'(fifo_level), 0, "level after ignored writes");
    chk("R1", int'(busy), 0, "busy after ignored writes");

    // R4/R6: every timebase, alternating levels, back to back
    push_sym(1, 0, 3, 1);
    push_sym(0, 1, 2, 1);
    push_sym(1, 2, 1, 1);
    push_sym(0, 3, 4, 1);
    push_sym(1, 3, 0, 1);
    push_sym(0, 0, 5, 1);
    drain();
    chk("R7", int'(carrier_gate), 0, "gate after drain");
    chk("R7", int'(busy), 0, "busy after drain");

    // R5: maximum delay, then restart after idle (R7)
    push_sym(1, 0, 1023, 1);
    push_sym(0, 2, 0, 1);
    drain();

    // R8/R9: threshold 2 with enable off: no interrupt
    wr(1, 17'h00002);
    repeat (3) @(negedge clk);
    chk("R8", int'(irq), 0, "irq with enable clear");
    wr(1, 17'h00102);
    repeat (2) @(negedge clk);
    chk("R9", int'(irq), 1, "irq after enable at level 0");
    wr(1, 17'h10102);
    @(negedge clk);
    chk("R10", int'(irq), 1, "irq after write with pending bit 1");
    wr(1, 17'h00102);
    @(negedge clk);
    chk("R10", int'(irq), 0, "irq after clear");
    push_sym(1, 2, 5, 1);
    push_sym(0, 1, 1, 1);
    push_sym(1, 0, 2, 1);
    push_sym(0, 3, 3, 1);
    push_sym(1, 1, 0, 1);
    chk("R9", int'(irq), 0, "irq while above threshold");
    chk("R2", int'(fifo_level), 4, "level after five pushes");
    drain();
    chk("R9", int'(irq), 1, "irq after falling to threshold");

    // R11: fill past full
    mon_en = 0;
    push_sym(0, 2, 1023, 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 128; i++) push_sym(0, 2, 1023, 0);
    chk("R2", int'(fifo_level), 128, "level when full");
    chk("R11", int'(overflow), 0, "overflow before extra push");
    push_sym(1, 2, 7, 0);
    chk("R11", int'(fifo_level), 128, "level after dropped push");
    chk("R11", int'(overflow), 1, "overflow after dropped push");
    repeat (3) @(negedge clk);
    chk("R11", int'(overflow), 1, "overflow stays set");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", int'(overflow), 0, "overflow cleared by reset");
    chk("R6", q.size(), 0, "unplayed expected symbols");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule